// File: doc/BRIEF.md
# Transmit Descriptor Ring Frame Gatherer

This block pulls outgoing frames out of host memory for one serial channel. Software builds a ring of 8-byte descriptors. Word 0 of each descriptor carries the control flags and a length field, and word 1 carries a byte address of a data buffer. A scan trigger tells the block to work through the ring. For each frame it first walks the chain of descriptors to make sure every one of them is owned, then gathers the segment bytes in ring order and streams them out one byte at a time. A few zero bytes of padding may follow, and the final byte is marked. Each descriptor is handed back to software by writing zero to its word 0.

Two chip modes change the arithmetic. They set how a segment's byte count is read out of word 0, and at which point the ring pointer wraps back to the ring start. One trigger handles a bounded number of frames. A single-cycle event pulse marks each frame that has been fully released.

Top module: `tx_ring_gatherer`

## Requirements
- R1: A scan only begins while `chan_active` and `tx_enable` are high and `ring_start` is nonzero, and only when word 0 at the current pointer has its owned bit (bit 31) set. Otherwise no bytes are sent, no event fires and no descriptor is written.
- R2: In mode 0 (`chip_mode`=0), a segment carries exactly the byte count held in word 0 bits [15:0].
- R3: In mode 1, a segment carries bits [15:0] times four bytes. When bit 20 is set, the value in bits [25:24] is subtracted from that, and a result below zero counts as zero.
- R4: Bytes leave in ring order and in address order within each buffer. Byte address A is taken from lane A[1:0] of the 32-bit word at A with the low two bits cleared, with lane 0 in bits [7:0]. `out_last` is high only on the final byte of a frame, pad bytes included.
- R5: After the data come (P-1)&3 zero bytes, where P is bits [23:22] of the descriptor that has the last-segment bit (bit 29) set. A frame whose data total is zero emits no bytes at all.
- R6: Every descriptor without the first-segment bit (bit 30) gets word 0 written to zero right after its data. The descriptor where the frame began gets word 0 cleared only after the whole frame.
- R7: If any descriptor after the first in a chain is not owned, or the walk comes back to its starting point, the frame is abandoned. No bytes, no event, no descriptor writes, an unchanged pointer, and the scan stops.
- R8: In mode 0 the pointer becomes pointer+8, or `ring_start` if that sum equals `ring_end`. In mode 1 the pointer becomes `ring_start` if it equals `ring_end`, and pointer+8 otherwise. A `ring_load` pulse while idle sets the pointer to `ring_start`.
- R9: `tx_event` is high for exactly one cycle per completed frame, and that includes frames with no data.
- R10: One scan trigger completes at most MAX_FRAMES (16) frames. A second trigger goes on from where the first one stopped.
- R11: A segment whose computed length is zero causes no read of its buffer.
- R12: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold steady, and no further buffer read is issued.
- R13: A memory request keeps `mem_addr` and `mem_we` stable until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_mode | input | 1 | Length and wrap rule select (0 or 1) |
| chan_active | input | 1 | Channel is active |
| tx_enable | input | 1 | Transmit enabled for the channel |
| ring_start | input | AW | Byte address of the first descriptor |
| ring_end | input | AW | Wrap boundary address |
| ring_load | input | 1 | Set the current pointer to ring_start (while idle) |
| scan_trig | input | 1 | Start a ring scan |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access done; read data valid |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of a frame |
| out_ready | input | 1 | Sink accepts the byte |
| tx_event | output | 1 | One-cycle pulse per completed frame |

## Verification
The bench goes after the ring boundary in both modes. A design that applied the wrong wrap rule would jump past the last slot in mode 0, or skip it in mode 1, so the follow-up frame would never be found. A chain whose second descriptor is not owned must leave memory untouched and stream nothing. A design that streamed while it walked the chain would emit a partial frame. Two more cases check the arithmetic: mode-1 lengths with the subtractor, and pad-field decoding that must give 3 bytes for field 0. An off-by-one here would shift `out_last`. Empty segments, empty frames, the 16-frame cap across two triggers, and a stalled sink are also covered. A stalled sink catches a design that issues reads into a full output register and loses bytes.

// File: rtl/txg_pkg.sv
package txg_pkg;
  localparam int OWN_BIT   = 31;
  localparam int FIRST_BIT = 30;
  localparam int LAST_BIT  = 29;
  localparam int SUBEN_BIT = 20;
  localparam int DESC_BYTES = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_W0, S_W1, S_DAT, S_NEXT, S_PAD, S_FREL, S_EVT
  } txg_state_e;
endpackage

// File: rtl/txg_seg_len.sv
module txg_seg_len #(
  parameter int LW = 24
) (
  input  logic          mode,
  input  logic [15:0]   len_field,
  input  logic          sub_en,
  input  logic [1:0]    sub_field,
  output logic [LW-1:0] seg_len
);
  logic [17:0] base;
  logic [17:0] sub;

  always_comb begin
    base = mode ? {len_field, 2'b00} : {2'b00, len_field};
    sub  = (mode && sub_en) ? {16'd0, sub_field} : 18'd0;
    seg_len = (base < sub) ? '0 : LW'(base - sub);
  end
endmodule

// File: rtl/txg_ring_step.sv
module txg_ring_step #(
  parameter int AW = 32
) (
  input  logic          mode,
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] rstart,
  input  logic [AW-1:0] rend,
  output logic [AW-1:0] nxt
);
  localparam logic [AW-1:0] STEP = AW'(txg_pkg::DESC_BYTES);
  logic [AW-1:0] inc;

  always_comb begin
    inc = ptr + STEP;
    if (mode) nxt = (ptr == rend) ? rstart : inc;
    else      nxt = (inc == rend) ? rstart : inc;
  end
endmodule

// File: rtl/tx_ring_gatherer.sv
module tx_ring_gatherer #(
  parameter int AW         = 32,
  parameter int LW         = 24,
  parameter int MAX_FRAMES = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chip_mode,
  input  logic          chan_active,
  input  logic          tx_enable,
  input  logic [AW-1:0] ring_start,
  input  logic [AW-1:0] ring_end,
  input  logic          ring_load,
  input  logic          scan_trig,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_last,
  input  logic          out_ready,
  output logic          tx_event
);
  import txg_pkg::*;

  localparam int FCW = $clog2(MAX_FRAMES + 1);
  localparam logic [FCW-1:0] FMAX = FCW'(MAX_FRAMES);

  txg_state_e    state;
  logic [AW-1:0] cur, fptr, wptr, baddr;
  logic [LW-1:0] tot, total, sent, remaining;
  logic          seg_fs, seg_ls;
  logic [FCW-1:0] frames;

  logic [LW-1:0] slen, chk_tot;
  logic [AW-1:0] wnext, cnext;
  logic [1:0]    pad_cnt;
  logic          start_ok;

  txg_seg_len #(.LW(LW)) u_len (
    .mode(chip_mode), .len_field(mem_rdata[15:0]),
    .sub_en(mem_rdata[SUBEN_BIT]), .sub_field(mem_rdata[25:24]),
    .seg_len(slen)
  );

  txg_ring_step #(.AW(AW)) u_walk (
    .mode(chip_mode), .ptr(wptr), .rstart(ring_start), .rend(ring_end), .nxt(wnext)
  );

  txg_ring_step #(.AW(AW)) u_adv (
    .mode(chip_mode), .ptr(cur), .rstart(ring_start), .rend(ring_end), .nxt(cnext)
  );

  assign chk_tot  = tot + slen;
  assign pad_cnt  = mem_rdata[23:22] - 2'd1;
  assign start_ok = chan_active && tx_enable && (ring_start != '0);
  assign mem_wdata = 32'd0;

  always_comb begin
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = '0;
    case (state)
      S_CHK:  begin mem_req = 1'b1; mem_addr = wptr; end
      S_W0:   begin mem_req = 1'b1; mem_addr = cur; end
      S_W1:   begin mem_req = 1'b1; mem_addr = cur + AW'(4); end
      S_DAT:  begin mem_req = !out_valid; mem_addr = {baddr[AW-1:2], 2'b00}; end
      S_NEXT: begin mem_req = !seg_fs; mem_we = 1'b1; mem_addr = cur; end
      S_FREL: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = fptr; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cur <= '0; fptr <= '0; wptr <= '0; baddr <= '0;
      tot <= '0; total <= '0; sent <= '0; remaining <= '0;
      seg_fs <= 1'b0; seg_ls <= 1'b0; frames <= '0;
      out_valid <= 1'b0; out_data <= '0; out_last <= 1'b0;
      tx_event <= 1'b0;
    end else begin
      tx_event <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (ring_load) cur <= ring_start;
          else if (scan_trig && start_ok) begin
            frames <= '0; wptr <= cur; fptr <= cur; tot <= '0;
            state <= S_CHK;
          end
        end
        S_CHK: if (mem_ack) begin
          if (!mem_rdata[OWN_BIT]) state <= S_IDLE;
          else if (mem_rdata[LAST_BIT]) begin
            total <= (chk_tot == '0) ? '0 : chk_tot + LW'(pad_cnt);
            sent  <= '0;
            state <= S_W0;
          end else begin
            tot <= chk_tot;
            if (wnext == fptr) state <= S_IDLE;
            else wptr <= wnext;
          end
        end
        S_W0: if (mem_ack) begin
          seg_fs    <= mem_rdata[FIRST_BIT];
          seg_ls    <= mem_rdata[LAST_BIT];
          remaining <= slen;
          state     <= (slen != '0) ? S_W1 : S_NEXT;
        end
        S_W1: if (mem_ack) begin
          baddr <= mem_rdata[AW-1:0];
          state <= S_DAT;
        end
        S_DAT: if (mem_ack) begin
          out_valid <= 1'b1;
          out_data  <= mem_rdata[{baddr[1:0], 3'b000} +: 8];
          out_last  <= (sent + LW'(1) == total);
          sent      <= sent + LW'(1);
          baddr     <= baddr + AW'(1);
          remaining <= remaining - LW'(1);
          if (remaining == LW'(1)) state <= S_NEXT;
        end
        S_NEXT: if (seg_fs || mem_ack) begin
          cur <= cnext;
          if (seg_ls) state <= (sent != total) ? S_PAD : S_FREL;
          else        state <= S_W0;
        end
        S_PAD: if (!out_valid) begin
          out_valid <= 1'b1;
          out_data  <= 8'd0;
          out_last  <= (sent + LW'(1) == total);
          sent      <= sent + LW'(1);
          if (sent + LW'(1) == total) state <= S_FREL;
        end
        S_FREL: if (mem_ack) state <= S_EVT;
        S_EVT: begin
          tx_event <= 1'b1;
          frames   <= frames + FCW'(1);
          if ((frames + FCW'(1)) < FMAX && start_ok) begin
            wptr <= cur; fptr <= cur; tot <= '0;
            state <= S_CHK;
          end else state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R13: request held with stable address and direction until acknowledged
  p_req_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R12: output byte held while the sink stalls
  p_out_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R9: event is a single-cycle pulse
  p_evt_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    tx_event |=> !tx_event);

  // R10: frame count per scan stays within the cap
  always_ff @(posedge clk) begin
    if (!rst) p_frame_cap_r10: assert (frames <= FMAX);
  end
endmodule

// File: tb/tb_tx_ring_gatherer.sv
module tb_tx_ring_gatherer;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] OWN = 32'h8000_0000;
  localparam logic [31:0] FS  = 32'h4000_0000;
  localparam logic [31:0] LS  = 32'h2000_0000;
  localparam logic [31:0] SUB = 32'h0010_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic chip_mode = 1'b0, chan_active = 1'b1, tx_enable = 1'b1;
  logic [31:0] ring_start = '0, ring_end = '0;
  logic ring_load = 1'b0, scan_trig = 1'b0;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic out_valid, out_last, out_ready = 1'b1, tx_event;
  logic [7:0] out_data;
  logic bp = 1'b0;
  int bpc = 0;

  logic [31:0] mem [0:255];
  logic [7:0] got[$], expb[$];
  bit gotl[$], expl[$];
  int evc = 0, zrd = 0, nchk = 0, nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_ring_gatherer dut (
    .clk(clk), .rst(rst), .chip_mode(chip_mode), .chan_active(chan_active),
    .tx_enable(tx_enable), .ring_start(ring_start), .ring_end(ring_end),
    .ring_load(ring_load), .scan_trig(scan_trig), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
    .tx_event(tx_event)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
      else begin
        mem_rdata <= mem[mem_addr[9:2]];
        if (mem_addr[9:4] == 6'h3F) zrd++;
      end
    end
    if (out_valid && out_ready) begin got.push_back(out_data); gotl.push_back(out_last); end
    if (tx_event) evc++;
  end

  always @(negedge clk) begin
    bpc++;
    out_ready <= !bp || (bpc % 3 == 0);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_desc(input int a, input logic [31:0] w0, input logic [31:0] w1);
    mem[a >> 2] = w0;
    mem[(a >> 2) + 1] = w1;
  endtask

  task automatic add_exp(input int a, input int n, input bit fin);
    for (int k = 0; k < n; k++) begin
      expb.push_back(pat(a + k));
      expl.push_back(fin && (k == n - 1));
    end
  endtask

  task automatic add_zero(input int n);
    for (int k = 0; k < n; k++) begin
      expb.push_back(8'd0);
      expl.push_back(k == n - 1);
    end
  endtask

  task automatic clear_obs();
    got.delete(); gotl.delete(); expb.delete(); expl.delete();
    evc = 0; zrd = 0;
  endtask

  task automatic check_bytes(input string tag);
    int bad;
    bad = -1;
    if (got.size() == expb.size())
      for (int i = 0; i < got.size(); i++)
        if (bad < 0 && (got[i] != expb[i] || gotl[i] != expl[i])) bad = i;
    if (got.size() != expb.size())
      check(1'b0, {tag, " byte count"}, got.size(), expb.size());
    else if (bad >= 0)
      check(1'b0, {tag, " byte/last"}, {23'd0, gotl[bad], got[bad]}, {23'd0, expl[bad], expb[bad]});
    else check(1'b1, tag, 0, 0);
  endtask

  task automatic load_ring(input int s, input int e);
    @(negedge clk);
    ring_start = s; ring_end = e; ring_load = 1'b1;
    @(negedge clk);
    ring_load = 1'b0;
  endtask

  task automatic run_scan();
    @(negedge clk); scan_trig = 1'b1;
    @(negedge clk); scan_trig = 1'b0;
    repeat (1500) @(negedge clk);
  endtask

  // R2 R4 R6 R9: mode 0 single segment, unaligned buffer, no pad
  task automatic t_mode0_single();
    clear_obs();
    chip_mode = 1'b0;
    load_ring(32'h40, 32'h60);
    set_desc(32'h40, OWN | FS | LS | (32'd1 << 22) | 32'd5, 32'h203);
    add_exp(32'h203, 5, 1'b1);
    run_scan();
    check_bytes("R2 R4 mode0 single");
    check(evc == 1, "R9 one event", evc, 1);
    check(mem[32'h40 >> 2] == 0, "R6 first released", mem[32'h40 >> 2], 0);
  endtask

  // R5 R6: two segments, pad field 0 gives three zeros
  task automatic t_two_seg_pad();
    clear_obs();
    set_desc(32'h48, OWN | FS | 32'd3, 32'h300);
    set_desc(32'h50, OWN | LS | 32'd2, 32'h310);
    add_exp(32'h300, 3, 1'b0); add_exp(32'h310, 2, 1'b0); add_zero(3);
    run_scan();
    check_bytes("R5 pad three");
    check(mem[32'h50 >> 2] == 0, "R6 non-first released", mem[32'h50 >> 2], 0);
    check(mem[32'h48 >> 2] == 0, "R6 first released", mem[32'h48 >> 2], 0);
  endtask

  // R7 then R8: abandon on unowned follower, then completion across the mode 0 wrap
  task automatic t_abandon_wrap();
    logic [31:0] w;
    clear_obs();
    w = OWN | FS | 32'd2;
    set_desc(32'h58, w, 32'h330);
    run_scan();
    check(got.size() == 0, "R7 no bytes", got.size(), 0);
    check(evc == 0, "R7 no event", evc, 0);
    check(mem[32'h58 >> 2] == w, "R7 desc untouched", mem[32'h58 >> 2], w);
    clear_obs();
    set_desc(32'h40, OWN | LS | (32'd1 << 22) | 32'd4, 32'h320);
    add_exp(32'h330, 2, 1'b0); add_exp(32'h320, 4, 1'b1);
    run_scan();
    check_bytes("R8 mode0 wrap gather");
    check(evc == 1, "R8 event after wrap", evc, 1);
  endtask

  // R3 R8: mode 1 lengths with subtractor and wrap-after-check
  task automatic t_mode1();
    clear_obs();
    chip_mode = 1'b1;
    load_ring(32'h80, 32'h88);
    set_desc(32'h80, OWN | FS | LS | SUB | (32'd2 << 24) | (32'd2 << 22) | 32'd3, 32'h280);
    set_desc(32'h88, OWN | FS | LS | (32'd1 << 22) | 32'd1, 32'h290);
    add_exp(32'h280, 10, 1'b0); add_zero(1);
    add_exp(32'h290, 4, 1'b1);
    run_scan();
    check_bytes("R3 mode1 lengths");
    check(evc == 2, "R9 two events", evc, 2);
    clear_obs();
    set_desc(32'h80, OWN | FS | LS | (32'd1 << 22) | 32'd1, 32'h2A0);
    add_exp(32'h2A0, 4, 1'b1);
    run_scan();
    check_bytes("R8 mode1 wrap");
  endtask

  // R11 R5 R9: zero-length segment and an empty frame
  task automatic t_zero_len();
    clear_obs();
    chip_mode = 1'b0;
    load_ring(32'hC0, 32'h100);
    set_desc(32'hC0, OWN | FS | 32'd0, 32'h3F0);
    set_desc(32'hC8, OWN | LS | (32'd1 << 22) | 32'd3, 32'h340);
    set_desc(32'hD0, OWN | FS | LS | 32'd0, 32'h3F4);
    add_exp(32'h340, 3, 1'b1);
    run_scan();
    check_bytes("R11 skip empty segment");
    check(zrd == 0, "R11 no buffer read", zrd, 0);
    check(evc == 2, "R9 empty frame event", evc, 2);
    check(mem[32'hD0 >> 2] == 0, "R5 empty frame released", mem[32'hD0 >> 2], 0);
  endtask

  // R10: frame cap per trigger
  task automatic t_cap();
    clear_obs();
    load_ring(32'h100, 32'h1A0);
    for (int i = 0; i < 20; i++) begin
      set_desc(32'h100 + 8 * i, OWN | FS | LS | (32'd1 << 22) | 32'd1, 32'h240 + i);
      if (i < 16) add_exp(32'h240 + i, 1, 1'b1);
    end
    run_scan();
    check(evc == 16, "R10 capped events", evc, 16);
    check_bytes("R10 capped bytes");
    clear_obs();
    for (int i = 16; i < 20; i++) add_exp(32'h240 + i, 1, 1'b1);
    run_scan();
    check(evc == 4, "R10 resumed events", evc, 4);
    check_bytes("R10 resumed bytes");
  endtask

  // R1: gating conditions
  task automatic t_gating();
    logic [31:0] w;
    clear_obs();
    load_ring(32'h1C0, 32'h1E0);
    w = OWN | FS | LS | (32'd1 << 22) | 32'd2;
    set_desc(32'h1C0, w, 32'h2F0);
    chan_active = 1'b0; run_scan();
    check(evc == 0 && got.size() == 0, "R1 inactive channel", evc, 0);
    chan_active = 1'b1; tx_enable = 1'b0; run_scan();
    check(evc == 0 && got.size() == 0, "R1 tx disabled", evc, 0);
    tx_enable = 1'b1; ring_start = 32'h0; run_scan();
    check(evc == 0 && mem[32'h1C0 >> 2] == w, "R1 zero ring start", evc, 0);
    ring_start = 32'h1C0;
    add_exp(32'h2F0, 2, 1'b1);
    run_scan();
    check_bytes("R1 enabled frame");
  endtask

  // R12: stalled sink
  task automatic t_backpressure();
    clear_obs();
    bp = 1'b1;
    set_desc(32'h1C8, OWN | FS | LS | (32'd3 << 22) | 32'd7, 32'h2E1);
    add_exp(32'h2E1, 7, 1'b0); add_zero(2);
    run_scan();
    bp = 1'b0;
    check_bytes("R12 stalled sink");
    check(evc == 1, "R12 event", evc, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++)
      mem[i] = (i < 128) ? 32'd0 : {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 0, "reset out_valid", out_valid, 0);
    check(tx_event == 0, "reset tx_event", tx_event, 0);
    check(mem_req == 0, "reset mem_req", mem_req, 0);
    t_mode0_single();
    t_two_seg_pad();
    t_abandon_wrap();
    t_mode1();
    t_zero_len();
    t_cap();
    t_gating();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule